// File: doc/BRIEF.md
# Page-Buffered Storage Write Engine

This block sits behind a two-wire serial bus front-end and turns a burst of write data into one timed update of a 256-byte storage array. The front-end first hands over a starting byte address and then one data byte at a time. The upper four address bits select a 16-byte page, and they stay fixed for the whole burst. The lower four bits pick a slot in a 16-entry holding buffer. Each received byte advances the slot pointer, and the pointer wraps within the page. A per-slot valid mask records which slots have been filled.

When the front-end sees a Stop condition it pulses `commit_i`. The block then starts a write cycle of fixed length. During that cycle `busy_o` is high, and it tells the front-end to stop acknowledging. At the end of the cycle only the slots that were filled are copied into the array, unless the write-protect input was high at the moment of commit. A blocked write still takes the full cycle. Reading the array over the bus is outside this block. A combinational inspection port lets the surrounding logic see any array byte.

Top module: `eep_page_commit`

## Requirements
- R1: After reset `busy_o` is 0 and every array byte reads 00h on the inspection port.
- R2: An address load followed by one data byte and a commit updates only that address. The new value is visible on `look_data_o` in the cycle after `busy_o` falls.
- R3: Each accepted data byte is stored at the current slot, and then only the low 4 address bits increment, modulo 16. A burst starting at offset 14 of a page continues at offsets 15, 0, 1 of that same page.
- R4: When more than 16 bytes arrive before a commit, the later bytes overwrite the earlier ones in the buffer. The array receives the last byte sent for each slot.
- R5: Only slots that received a byte since the valid mask was last cleared are written. All other bytes of the page keep their previous array contents.
- R6: If `wp_i` is 1 in the cycle `commit_i` is accepted, no array byte changes. `busy_o` is still high for exactly WR_CYCLES cycles.
- R7: An accepted commit raises `busy_o` on the next clock edge, and `busy_o` stays high for exactly WR_CYCLES clock cycles.
- R8: The write-protect level is captured when the commit is accepted. Changing `wp_i` while `busy_o` is high has no effect on the outcome.
- R9: While `busy_o` is high, `addr_load_i`, `data_valid_i` and `commit_i` are ignored. They change neither the buffer, the slot pointer nor the array, and they do not extend the cycle.
- R10: The valid mask is cleared by an address load and by the end of every write cycle. The slot pointer and page are kept after a cycle ends, so bytes sent without a new address continue from the next offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load_i | input | 1 | Load a new starting address (takes priority over a data byte) |
| addr_i | input | 8 | Starting byte address: bits 7:4 page, bits 3:0 slot |
| data_valid_i | input | 1 | One data byte is offered this cycle |
| data_i | input | 8 | Data byte |
| commit_i | input | 1 | Stop seen: start the write cycle |
| wp_i | input | 1 | Write protect, 1 blocks writes to all addresses |
| busy_o | output | 1 | Write cycle in progress |
| look_addr_i | input | 8 | Inspection address |
| look_data_o | output | 8 | Array byte at the inspection address |

## Verification
The hardest cases are those in which buffer state left over from an earlier burst could leak into a later commit. One example is a valid mask that is not cleared after a cycle ends. In that case a stale slot would rewrite an address that has since held a different value. To reach that case, the stimulus first stores a byte, then loads a new value into the same slot under write protection, and then sends a byte without a new address. Stray inputs during a busy cycle are also injected, and write protect is toggled mid-cycle. Each of these is followed by a later commit that would expose the fault.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int EEP_ADDR_W = 8;
    localparam int EEP_OFF_W  = 4;
    localparam int EEP_DATA_W = 8;
    localparam int EEP_WR_CYC = 20;

    typedef enum logic [0:0] {
        CYC_IDLE = 1'b0,
        CYC_RUN  = 1'b1
    } cyc_state_e;

    typedef struct packed {
        logic busy;
        logic done;
        logic wp_hold;
    } cyc_stat_t;

    function automatic logic [EEP_OFF_W-1:0] next_slot(input logic [EEP_OFF_W-1:0] cur);
        return cur + 1'b1;
    endfunction

endpackage

// File: rtl/eep_wr_timer.sv
module eep_wr_timer
    import eep_pkg::*;
#(
    parameter int WR_CYCLES = EEP_WR_CYC
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      wp_i,
    output cyc_stat_t stat_o
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    cyc_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             wp_lat_q;
    logic             busy;
    logic             last;

    assign busy = (state_q == CYC_RUN);
    assign last = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= CYC_IDLE;
            cnt_q    <= '0;
            wp_lat_q <= 1'b0;
        end else if (!busy) begin
            if (start_i) begin
                state_q  <= CYC_RUN;
                cnt_q    <= CNT_W'(WR_CYCLES - 1);
                wp_lat_q <= wp_i;
            end
        end else if (last) begin
            state_q <= CYC_IDLE;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign stat_o.busy    = busy;
    assign stat_o.done    = last;
    assign stat_o.wp_hold = wp_lat_q;

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_i));
    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q < CNT_W'(WR_CYCLES)));
    // R8
    wp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(wp_lat_q));

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf
    import eep_pkg::*;
#(
    parameter int ADDR_W = EEP_ADDR_W,
    parameter int OFF_W  = EEP_OFF_W,
    parameter int DATA_W = EEP_DATA_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           busy_i,
    input  logic                           clr_i,
    input  logic                           load_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic                           wr_i,
    input  logic [DATA_W-1:0]              data_i,
    output logic [ADDR_W-OFF_W-1:0]        page_o,
    output logic [(1<<OFF_W)-1:0]          mask_o,
    output logic [(1<<OFF_W)-1:0][DATA_W-1:0] slots_o
);
    localparam int SLOTS  = 1 << OFF_W;
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  ptr_q;
    logic [SLOTS-1:0]  mask_q;
    logic              take_load;
    logic              take_byte;

    assign take_load = load_i && !busy_i;
    assign take_byte = wr_i && !busy_i && !load_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            ptr_q  <= '0;
            mask_q <= '0;
        end else if (clr_i) begin
            mask_q <= '0;
        end else if (take_load) begin
            page_q <= addr_i[ADDR_W-1:OFF_W];
            ptr_q  <= addr_i[OFF_W-1:0];
            mask_q <= '0;
        end else if (take_byte) begin
            mask_q[ptr_q] <= 1'b1;
            ptr_q         <= OFF_W'(next_slot(EEP_OFF_W'(ptr_q)));
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [DATA_W-1:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst)
                byte_q <= '0;
            else if (take_byte && (ptr_q == OFF_W'(s)))
                byte_q <= data_i;
        end
        assign slots_o[s] = byte_q;
    end

    assign page_o = page_q;
    assign mask_o = mask_q;

    // R9
    busy_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> ($stable(ptr_q) && $stable(page_q)));
    // R9
    busy_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !clr_i) |=> $stable(mask_q));
    // R10
    clr_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i || (load_i && !busy_i)) |=> (mask_q == '0));
    // R3
    byte_one_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !busy_i && !load_i && !clr_i) |=> ($countones(mask_q) >= 1));

endmodule

// File: rtl/eep_store.sv
module eep_store
    import eep_pkg::*;
#(
    parameter int ADDR_W = EEP_ADDR_W,
    parameter int OFF_W  = EEP_OFF_W,
    parameter int DATA_W = EEP_DATA_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              put_i,
    input  logic [ADDR_W-OFF_W-1:0]           page_i,
    input  logic [(1<<OFF_W)-1:0]             mask_i,
    input  logic [(1<<OFF_W)-1:0][DATA_W-1:0] slots_i,
    input  logic [ADDR_W-1:0]                 look_addr_i,
    output logic [DATA_W-1:0]                 look_data_o
);
    localparam int SLOTS = 1 << OFF_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < DEPTH; a++)
                mem_q[a] <= '0;
        end else if (put_i) begin
            for (int s = 0; s < SLOTS; s++)
                if (mask_i[s])
                    mem_q[{page_i, OFF_W'(s)}] <= slots_i[s];
        end
    end

    assign look_data_o = mem_q[look_addr_i];

endmodule

// File: rtl/eep_page_commit.sv
module eep_page_commit
    import eep_pkg::*;
#(
    parameter int ADDR_W    = EEP_ADDR_W,
    parameter int OFF_W     = EEP_OFF_W,
    parameter int DATA_W    = EEP_DATA_W,
    parameter int WR_CYCLES = EEP_WR_CYC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              data_valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              commit_i,
    input  logic              wp_i,
    output logic              busy_o,
    input  logic [ADDR_W-1:0] look_addr_i,
    output logic [DATA_W-1:0] look_data_o
);
    localparam int SLOTS  = 1 << OFF_W;
    localparam int PAGE_W = ADDR_W - OFF_W;

    cyc_stat_t                    stat;
    logic [PAGE_W-1:0]            page;
    logic [SLOTS-1:0]             mask;
    logic [SLOTS-1:0][DATA_W-1:0] slots;
    logic                         start;
    logic                         put;

    assign start = commit_i && !stat.busy;
    assign put   = stat.done && !stat.wp_hold;

    eep_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .wp_i    (wp_i),
        .stat_o  (stat)
    );

    eep_page_buf #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .busy_i  (stat.busy),
        .clr_i   (stat.done),
        .load_i  (addr_load_i),
        .addr_i  (addr_i),
        .wr_i    (data_valid_i),
        .data_i  (data_i),
        .page_o  (page),
        .mask_o  (mask),
        .slots_o (slots)
    );

    eep_store #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .put_i       (put),
        .page_i      (page),
        .mask_i      (mask),
        .slots_i     (slots),
        .look_addr_i (look_addr_i),
        .look_data_o (look_data_o)
    );

    assign busy_o = stat.busy;

    // R6
    wp_block_chk: assert property (@(posedge clk) disable iff (rst)
        (stat.done && stat.wp_hold) |-> !put);
    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(stat.done));

endmodule

// File: tb/eep_page_commit_test.sv
`timescale 1ns/1ps
module eep_page_commit_test;
    localparam int WR = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr_load_i = 1'b0;
    logic [7:0] addr_i = '0;
    logic       data_valid_i = 1'b0;
    logic [7:0] data_i = '0;
    logic       commit_i = 1'b0;
    logic       wp_i = 1'b0;
    logic       busy_o;
    logic [7:0] look_addr_i = '0;
    logic [7:0] look_data_o;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [7:0] a;
        logic [7:0] d;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    logic [7:0] model [256];

    always #5 clk = ~clk;

    eep_page_commit #(.WR_CYCLES(WR)) uut (
        .clk(clk), .rst(rst),
        .addr_load_i(addr_load_i), .addr_i(addr_i),
        .data_valid_i(data_valid_i), .data_i(data_i),
        .commit_i(commit_i), .wp_i(wp_i), .busy_o(busy_o),
        .look_addr_i(look_addr_i), .look_data_o(look_data_o)
    );

    // monitor: pops expected bytes and compares the inspection port
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() != 0) begin
                exp_t it;
                it = sb_q.pop_front();
                look_addr_i = it.a;
                #1;
                n_cmp++;
                if (look_data_o !== it.d) begin
                    n_bad++;
                    $display("FAIL %s addr %02h: actual %02h expected %02h", it.tag, it.a, look_data_o, it.d);
                end
            end
        end
    end

    task automatic check_bit(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic expect_page(input logic [3:0] pg, input string tag);
        for (int i = 0; i < 16; i++) begin
            exp_t it;
            it.a = {pg, 4'(i)};
            it.d = model[{pg, 4'(i)}];
            it.tag = tag;
            sb_q.push_back(it);
        end
        wait (sb_q.size() == 0);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic [7:0] a);
        @(negedge clk);
        addr_load_i = 1'b1; addr_i = a;
        @(negedge clk);
        addr_load_i = 1'b0;
    endtask

    task automatic put(input logic [7:0] d);
        data_valid_i = 1'b1; data_i = d;
        @(negedge clk);
        data_valid_i = 1'b0;
    endtask

    // flip_at: busy cycle at which wp toggles (-1 none); inject: stray inputs while busy
    task automatic commit(input logic wpv, input int flip_at, input bit inject, input string tag);
        int cnt;
        commit_i = 1'b1; wp_i = wpv;
        @(negedge clk);
        commit_i = 1'b0;
        cnt = 0;
        while (busy_o === 1'b1 && cnt < 10 * WR) begin
            cnt++;
            if (cnt == flip_at) wp_i = ~wp_i;
            if (inject && cnt == 3) begin
                addr_load_i = 1'b1; addr_i = 8'h90;
            end else if (inject && cnt == 4) begin
                addr_load_i = 1'b0; data_valid_i = 1'b1; data_i = 8'hEE;
            end else if (inject && cnt == 5) begin
                data_valid_i = 1'b0; commit_i = 1'b1;
            end else begin
                addr_load_i = 1'b0; data_valid_i = 1'b0; commit_i = 1'b0;
            end
            @(negedge clk);
        end
        addr_load_i = 1'b0; data_valid_i = 1'b0; commit_i = 1'b0;
        n_cmp++;
        if (cnt != WR) begin
            n_bad++;
            $display("FAIL %s busy length: actual %0d expected %0d", tag, cnt, WR);
        end
        wp_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) model[a] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_bit(busy_o, 1'b0, "R1 busy after reset");
        expect_page(4'h0, "R1");
        expect_page(4'hF, "R1");

        // R2 single byte, R7 busy length
        load(8'h12); put(8'hA5); commit(1'b0, -1, 1'b0, "R7 byte write");
        model[8'h12] = 8'hA5;
        expect_page(4'h1, "R2");

        // R3 low nibble wrap within page
        load(8'h3E); put(8'h11); put(8'h22); put(8'h33); put(8'h44);
        commit(1'b0, -1, 1'b0, "R7");
        model[8'h3E] = 8'h11; model[8'h3F] = 8'h22;
        model[8'h30] = 8'h33; model[8'h31] = 8'h44;
        expect_page(4'h3, "R3");
        expect_page(4'h4, "R3 next page untouched");

        // R4 more than 16 bytes overwrite earliest slots
        load(8'h50);
        for (int i = 0; i < 18; i++) put(8'((i + 1) * 3));
        commit(1'b0, -1, 1'b0, "R7");
        for (int i = 0; i < 18; i++) model[8'h50 + (i % 16)] = 8'((i + 1) * 3);
        expect_page(4'h5, "R4");

        // R5 only received slots written
        load(8'h60);
        for (int i = 0; i < 16; i++) put(8'h60 + 8'(i));
        commit(1'b0, -1, 1'b0, "R7");
        for (int i = 0; i < 16; i++) model[8'h60 + i] = 8'h60 + 8'(i);
        load(8'h65); put(8'hC1); put(8'hC2);
        commit(1'b0, -1, 1'b0, "R7");
        model[8'h65] = 8'hC1; model[8'h66] = 8'hC2;
        expect_page(4'h6, "R5");

        // R6 protected write blocked, full cycle
        load(8'h12); put(8'hFF); commit(1'b1, -1, 1'b0, "R6 busy length under wp");
        expect_page(4'h1, "R6");

        // R8 wp sampled at commit only
        load(8'h20); put(8'h9A); commit(1'b0, 4, 1'b0, "R8");
        model[8'h20] = 8'h9A;
        load(8'h21); put(8'h9B); commit(1'b1, 4, 1'b0, "R8");
        expect_page(4'h2, "R8");

        // R9 inputs ignored while busy
        load(8'h80); put(8'h01); commit(1'b0, -1, 1'b1, "R9 busy length with stray inputs");
        model[8'h80] = 8'h01;
        put(8'h55); commit(1'b0, -1, 1'b0, "R9");
        model[8'h81] = 8'h55;
        expect_page(4'h8, "R9");
        expect_page(4'h9, "R9 stray address");

        // R10 address load clears mask
        load(8'hA0); put(8'h01); put(8'h02); put(8'h03);
        load(8'hA8); put(8'h07); commit(1'b0, -1, 1'b0, "R10");
        model[8'hA8] = 8'h07;
        expect_page(4'hA, "R10 load clears");

        // R10 cycle end clears mask, pointer kept
        load(8'h70); put(8'hAA); commit(1'b0, -1, 1'b0, "R10");
        load(8'h70); put(8'hCC); commit(1'b1, -1, 1'b0, "R10");
        put(8'hBB); commit(1'b0, -1, 1'b0, "R10");
        model[8'h70] = 8'hAA; model[8'h71] = 8'hBB;
        expect_page(4'h7, "R10 end clears");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule